// File: doc/BRIEF.md
# Forwarding and Overflow-Squash Unit

This block is the hazard-handling datapath of a small five-stage in-order integer pipeline. The fetch side hands it one three-operand instruction per cycle: a destination index, two source indices, a 16-bit immediate and the instruction's PC. The block holds decode, execute, memory and write-back stages and a register file model. When a source register in execute matches the destination of an instruction further down the pipe, the block feeds the newer result onto the ALU operand. Dependent code therefore produces the same results as a machine that runs one instruction at a time, with no padding between instructions.

Signed overflow on an add or a subtract is caught in execute. The faulting instruction is cancelled before it can write its destination, so that register keeps its old value even when it is also a source. The instruction waiting in decode and the one offered during the fault cycle are discarded. The fault is reported to the fetch side for one cycle together with the PC of the faulting instruction, and fetch then redirects. A load whose result is needed by the very next instruction holds decode for one cycle. Every register write that retires appears on a commit port.

Top module: `fwd_squash_core`

## Requirements
- R1: In the first cycle after a synchronous active-low reset, `in_ready` is 1 and `wb_valid` and `exc_valid` are 0. All registers read as zero.
- R2: Operation codes are 0 none, 1 add (rd=rs+rt), 2 subtract (rd=rs-rt), 3 bitwise and, 4 bitwise or and 5 load. Codes 6 and 7 act as none. Arithmetic wraps at 32 bits, and every retired result equals in-order sequential execution.
- R3: A source written by the immediately preceding ALU instruction receives that result without a stall.
- R4: A source written two or three instructions earlier receives the new value without a stall.
- R5: When the two preceding instructions both write a source, the younger instruction's value is used.
- R6: Register 0 reads as zero. It is never written, never forwarded and never reported on the commit port.
- R7: A load reads address rs plus the sign-extended immediate and returns {addr[15:0], ~addr[15:0]}. An instruction that needs that load's destination right after it sees `in_ready` low for exactly one cycle and gets the loaded value.
- R8: A signed overflow on add or subtract raises `exc_valid` for exactly one cycle with `exc_pc` equal to the faulting PC. `exc_pc` is zero at other times, and no other case raises `exc_valid`.
- R9: An overflowing instruction never writes its destination and is never committed. A later reader of that register sees the value from before the fault.
- R10: When `exc_valid` is high, the instruction in decode and the instruction accepted in that same cycle are discarded. Older instructions still retire.
- R11: `wb_valid` pulses once for each retired write to a non-zero register, in program order, carrying that register index on `wb_rd` and the written value on `wb_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is offered |
| in_op | input | 3 | Operation code |
| in_rd | input | 5 | Destination register index |
| in_rs | input | 5 | First source register index |
| in_rt | input | 5 | Second source register index |
| in_imm | input | 16 | Load offset, sign-extended |
| in_pc | input | 32 | PC of the offered instruction |
| in_ready | output | 1 | Offered instruction is taken at the next edge |
| exc_valid | output | 1 | Overflow fault in execute, redirect fetch |
| exc_pc | output | 32 | PC of the faulting instruction |
| wb_valid | output | 1 | A register write retires |
| wb_rd | output | 5 | Register written |
| wb_data | output | 32 | Value written |

## Verification
A bench reference machine executes the stream strictly one instruction at a time and compares every commit and every fault against the pipeline's outputs. The stream places consumers at distances one, two and three from their producers, which separates memory-stage forwarding, write-back forwarding and the register-file bypass. A pair of back-to-back writers to the same register shows whether the younger value wins. Loads are followed directly by readers on the first and on the second source, which tests both the one-cycle stall and the load data. Faults on an add whose destination is also a source, and on a subtract, are each followed by readers of the cancelled register and of the registers the discarded instructions would have written. These readers show whether squash and flush cover exactly the intended instructions.

// File: rtl/fsu_pkg.sv
// Shared types for the forwarding and overflow-squash pipeline.
// Assumes a 3-bit operation field; unlisted codes behave as no operation.
package fsu_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ADD = 3'd1,
        OP_SUB = 3'd2,
        OP_AND = 3'd3,
        OP_OR  = 3'd4,
        OP_LD  = 3'd5
    } op_e;

    // Where an execute operand is taken from.
    typedef enum logic [1:0] {
        FWD_FILE = 2'd0,
        FWD_MEM  = 2'd1,
        FWD_WB   = 2'd2
    } fwd_e;

    // True for operations that write a destination (and read the first source).
    function automatic logic op_writes(logic [2:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
               (op == OP_OR)  || (op == OP_LD);
    endfunction

    // True for operations that read the second source.
    function automatic logic op_reads_b(logic [2:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) || (op == OP_OR);
    endfunction

endpackage

// File: rtl/fsu_regfile.sv
// Register file model: RD_PORTS combinational read ports, one write port.
// Entry 0 is hard zero. A write in the same cycle as a read of the same
// entry is passed straight through, so decode never sees a stale value.
module fsu_regfile #(
    parameter int DATA_W   = 32,
    parameter int REG_CNT  = 32,
    parameter int RD_PORTS = 2,
    localparam int REG_AW  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_AW-1:0] raddr [RD_PORTS],
    output logic [DATA_W-1:0] rdata [RD_PORTS]
);

    logic [DATA_W-1:0] regs [REG_CNT];

    // Storage: cleared on reset, entry 0 never written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_CNT; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // One read path per port, with write-through.
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0)                    ? '0    :
                          (we && (waddr == raddr[p]))          ? wdata :
                                                                 regs[raddr[p]];
    end

endmodule

// File: rtl/fsu_hazard.sv
// Hazard detection: the load-use stall for decode and the operand source
// selection for execute. The memory stage wins over write-back; register 0
// and load results still in the memory stage are never forwarded.
module fsu_hazard
    import fsu_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              id_valid,
    input  logic              id_reads_a,
    input  logic              id_reads_b,
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic              ex_load,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic [REG_AW-1:0] ex_src [2],
    input  logic              mem_wr,
    input  logic              mem_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              wb_wr,
    input  logic [REG_AW-1:0] wb_rd,
    output logic              stall,
    output fwd_e              fwd_sel [2]
);

    logic load_hit_a;
    logic load_hit_b;

    // Load in execute feeding the instruction in decode: hold one cycle.
    always_comb begin
        load_hit_a = id_reads_a && (id_rs == ex_rd);
        load_hit_b = id_reads_b && (id_rt == ex_rd);
        stall      = id_valid && ex_load && (ex_rd != '0) && (load_hit_a || load_hit_b);
    end

    // Per-operand comparators, younger stage first.
    for (genvar k = 0; k < 2; k++) begin : g_opnd
        logic mem_hit;
        logic wb_hit;
        assign mem_hit = mem_wr && !mem_load && (mem_rd == ex_src[k]) && (ex_src[k] != '0);
        assign wb_hit  = wb_wr && (wb_rd == ex_src[k]) && (ex_src[k] != '0);
        assign fwd_sel[k] = mem_hit ? FWD_MEM : (wb_hit ? FWD_WB : FWD_FILE);
    end

endmodule

// File: rtl/fsu_alu.sv
// Execute-stage arithmetic: result and signed-overflow flag. For a load the
// result is the effective address (first operand plus sign-extended offset).
// Overflow is only ever raised by add and subtract.
module fsu_alu
    import fsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result,
    output logic              ovf
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] diff;
    logic [DATA_W-1:0] eaddr;

    // Operation select and overflow detection.
    always_comb begin
        sum    = a + b;
        diff   = a - b;
        eaddr  = a + {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
        result = '0;
        ovf    = 1'b0;
        case (op)
            OP_ADD: begin
                result = sum;
                ovf    = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
            end
            OP_SUB: begin
                result = diff;
                ovf    = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
            end
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            OP_LD:   result = eaddr;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/fwd_squash_core.sv
// Decode/execute/memory/write-back stages with result forwarding and an
// overflow squash. The fetch side offers instructions at in_*; in_ready low
// means the offer is held. An overflow in execute cancels that instruction's
// write, flushes decode, drops the instruction offered in the same cycle and
// reports the faulting PC for one cycle. The load value is a computed
// pattern of the address, which stands in for memory.
module fwd_squash_core
    import fsu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int REG_CNT = 32,
    parameter int IMM_W   = 16,
    parameter int PC_W    = 32,
    localparam int REG_AW = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [REG_AW-1:0] in_rd,
    input  logic [REG_AW-1:0] in_rs,
    input  logic [REG_AW-1:0] in_rt,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [PC_W-1:0]   in_pc,
    output logic              in_ready,
    output logic              exc_valid,
    output logic [PC_W-1:0]   exc_pc,
    output logic              wb_valid,
    output logic [REG_AW-1:0] wb_rd,
    output logic [DATA_W-1:0] wb_data
);

    localparam int HALF = DATA_W / 2;

    // Decode stage
    logic              id_valid;
    logic [2:0]        id_op;
    logic [REG_AW-1:0] id_rd, id_rs, id_rt;
    logic [IMM_W-1:0]  id_imm;
    logic [PC_W-1:0]   id_pc;

    // Execute stage
    logic              ex_valid;
    logic [2:0]        ex_op;
    logic [REG_AW-1:0] ex_rd;
    logic [REG_AW-1:0] ex_src [2];
    logic [IMM_W-1:0]  ex_imm;
    logic [PC_W-1:0]   ex_pc;
    logic [DATA_W-1:0] ex_val [2];

    // Memory stage
    logic              exm_wr;
    logic              exm_load;
    logic [REG_AW-1:0] exm_rd;
    logic [DATA_W-1:0] exm_res;

    // Write-back stage
    logic              wbq_wr;
    logic [REG_AW-1:0] wbq_rd;
    logic [DATA_W-1:0] wbq_data;

    // Interconnect
    logic [REG_AW-1:0] rf_raddr [2];
    logic [DATA_W-1:0] rf_rdata [2];
    logic [DATA_W-1:0] opnd [2];
    fwd_e              fwd_sel [2];
    logic [DATA_W-1:0] alu_res;
    logic              alu_ovf;
    logic              ovf_hit;
    logic              stall;
    logic [DATA_W-1:0] mem_data;

    assign rf_raddr[0] = id_rs;
    assign rf_raddr[1] = id_rt;

    fsu_regfile #(
        .DATA_W   (DATA_W),
        .REG_CNT  (REG_CNT),
        .RD_PORTS (2)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wbq_wr),
        .waddr (wbq_rd),
        .wdata (wbq_data),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    fsu_hazard #(
        .REG_AW (REG_AW)
    ) u_hz (
        .id_valid   (id_valid),
        .id_reads_a (op_writes(id_op)),
        .id_reads_b (op_reads_b(id_op)),
        .id_rs      (id_rs),
        .id_rt      (id_rt),
        .ex_load    (ex_valid && (ex_op == OP_LD)),
        .ex_rd      (ex_rd),
        .ex_src     (ex_src),
        .mem_wr     (exm_wr),
        .mem_load   (exm_load),
        .mem_rd     (exm_rd),
        .wb_wr      (wbq_wr),
        .wb_rd      (wbq_rd),
        .stall      (stall),
        .fwd_sel    (fwd_sel)
    );

    // Operand muxes in front of the ALU, one per source.
    for (genvar k = 0; k < 2; k++) begin : g_mux
        assign opnd[k] = (fwd_sel[k] == FWD_MEM) ? exm_res  :
                         (fwd_sel[k] == FWD_WB)  ? wbq_data :
                                                   ex_val[k];
    end

    fsu_alu #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_alu (
        .op     (ex_op),
        .a      (opnd[0]),
        .b      (opnd[1]),
        .imm    (ex_imm),
        .result (alu_res),
        .ovf    (alu_ovf)
    );

    assign ovf_hit  = ex_valid && alu_ovf;
    assign in_ready = !stall;
    assign exc_valid = ovf_hit;
    assign exc_pc    = ovf_hit ? ex_pc : '0;

    // Decode register: flushed on overflow, held on stall, else loads the offer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_valid <= 1'b0;
            id_op    <= OP_NOP;
            id_rd    <= '0;
            id_rs    <= '0;
            id_rt    <= '0;
            id_imm   <= '0;
            id_pc    <= '0;
        end else if (ovf_hit) begin
            id_valid <= 1'b0;
        end else if (!stall) begin
            id_valid <= in_valid;
            id_op    <= in_op;
            id_rd    <= in_rd;
            id_rs    <= in_rs;
            id_rt    <= in_rt;
            id_imm   <= in_imm;
            id_pc    <= in_pc;
        end
    end

    // Execute register: a bubble enters on stall or flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_valid  <= 1'b0;
            ex_op     <= OP_NOP;
            ex_rd     <= '0;
            ex_src[0] <= '0;
            ex_src[1] <= '0;
            ex_imm    <= '0;
            ex_pc     <= '0;
            ex_val[0] <= '0;
            ex_val[1] <= '0;
        end else if (ovf_hit || stall) begin
            ex_valid <= 1'b0;
            ex_op    <= OP_NOP;
        end else begin
            ex_valid  <= id_valid;
            ex_op     <= id_valid ? id_op : OP_NOP;
            ex_rd     <= id_rd;
            ex_src[0] <= id_rs;
            ex_src[1] <= id_rt;
            ex_imm    <= id_imm;
            ex_pc     <= id_pc;
            ex_val[0] <= rf_rdata[0];
            ex_val[1] <= rf_rdata[1];
        end
    end

    // Memory register: the write of an overflowing instruction is cancelled here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exm_wr   <= 1'b0;
            exm_load <= 1'b0;
            exm_rd   <= '0;
            exm_res  <= '0;
        end else begin
            exm_wr   <= ex_valid && !ovf_hit && op_writes(ex_op) && (ex_rd != '0);
            exm_load <= (ex_op == OP_LD);
            exm_rd   <= ex_rd;
            exm_res  <= alu_res;
        end
    end

    // Memory stand-in: a load returns the low half of the address and its inverse.
    assign mem_data = exm_load ? {exm_res[HALF-1:0], ~exm_res[HALF-1:0]} : exm_res;

    // Write-back register feeding the register file and the commit port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbq_wr   <= 1'b0;
            wbq_rd   <= '0;
            wbq_data <= '0;
        end else begin
            wbq_wr   <= exm_wr;
            wbq_rd   <= exm_rd;
            wbq_data <= mem_data;
        end
    end

    assign wb_valid = wbq_wr;
    assign wb_rd    = wbq_rd;
    assign wb_data  = wbq_data;

endmodule

// File: rtl/fwd_squash_core_chk.sv
// Port-level properties of fwd_squash_core. Attached to every instance by the
// bind statement at the end of this file. Assumes synchronous active-low reset.
module fwd_squash_core_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              exc_valid,
    input logic              wb_valid,
    input logic [REG_AW-1:0] wb_rd
);

    logic up_q;
    logic exc_d1;
    logic exc_d2;

    // History of the fault output, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q   <= 1'b0;
            exc_d1 <= 1'b0;
            exc_d2 <= 1'b0;
        end else begin
            up_q   <= 1'b1;
            exc_d1 <= exc_valid;
            exc_d2 <= exc_d1;
        end
    end

    // R1: idle outputs in the first cycle out of reset
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !up_q |-> (in_ready && !wb_valid && !exc_valid));

    // R6: register 0 never shows up on the commit port
    assert_no_r0_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_rd != '0));

    // R7: a load-use stall lasts a single cycle
    assert_stall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);

    // R8: the fault report is a one-cycle pulse
    assert_exc_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> !exc_valid);

    // R9: the faulting instruction never reaches write-back
    assert_squash_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_d2 |-> !wb_valid);

    // R10: a fault cycle never coincides with a decode hold
    assert_flush_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> in_ready);

endmodule

bind fwd_squash_core fwd_squash_core_chk #(.REG_AW(REG_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .exc_valid (exc_valid),
    .wb_valid  (wb_valid),
    .wb_rd     (wb_rd)
);

// File: tb/fwd_squash_core_tb.sv
`timescale 1ns/1ps
// Bench: a sequential reference machine runs each accepted instruction in
// program order; commits and faults of the pipeline are compared every cycle.
module fwd_squash_core_tb;

    typedef struct {
        bit          gap;
        logic [2:0]  op;
        logic [4:0]  rd;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [15:0] imm;
        string       tag;
    } ins_t;

    typedef struct {
        logic [4:0]  rd;
        logic [31:0] data;
        string       tag;
    } cmt_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  in_op;
    logic [4:0]  in_rd, in_rs, in_rt;
    logic [15:0] in_imm;
    logic [31:0] in_pc;
    logic        in_ready;
    logic        exc_valid;
    logic [31:0] exc_pc;
    logic        wb_valid;
    logic [4:0]  wb_rd;
    logic [31:0] wb_data;

    int n_tests = 0;
    int n_fail  = 0;

    ins_t        prog [$];
    cmt_t        exp_q [$];
    logic [31:0] exc_q [$];
    logic [31:0] arch [32];
    bit          kill = 0;

    always #4 clk = ~clk;

    fwd_squash_core u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_rd(in_rd), .in_rs(in_rs), .in_rt(in_rt), .in_imm(in_imm),
        .in_pc(in_pc), .in_ready(in_ready), .exc_valid(exc_valid),
        .exc_pc(exc_pc), .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data)
    );

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic put(logic [2:0] op, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt,
                       logic [15:0] imm, string tag);
        ins_t i;
        i.gap = 0; i.op = op; i.rd = rd; i.rs = rs; i.rt = rt; i.imm = imm; i.tag = tag;
        prog.push_back(i);
    endtask

    task automatic gap();
        ins_t i;
        i.gap = 1; i.op = 0; i.rd = 0; i.rs = 0; i.rt = 0; i.imm = 0; i.tag = "";
        prog.push_back(i);
    endtask

    // Sequential execution of one instruction (R2, R7, R8 semantics).
    task automatic iss(ins_t i, logic [31:0] pc);
        logic [31:0] a, b, r, ad;
        bit ovf;
        cmt_t c;
        a = (i.rs == 0) ? 32'd0 : arch[i.rs];
        b = (i.rt == 0) ? 32'd0 : arch[i.rt];
        r = 0; ovf = 0;
        case (i.op)
            3'd1: begin r = a + b; ovf = (a[31] == b[31]) && (r[31] != a[31]); end
            3'd2: begin r = a - b; ovf = (a[31] != b[31]) && (r[31] != a[31]); end
            3'd3: r = a & b;
            3'd4: r = a | b;
            3'd5: begin ad = a + {{16{i.imm[15]}}, i.imm}; r = {ad[15:0], ~ad[15:0]}; end
            default: r = 0;
        endcase
        if (ovf) begin
            exc_q.push_back(pc);
            kill = 1;
        end else if (i.op >= 3'd1 && i.op <= 3'd5 && i.rd != 0) begin
            arch[i.rd] = r;
            c.rd = i.rd; c.data = r; c.tag = i.tag;
            exp_q.push_back(c);
        end
    endtask

    initial begin
        int idx = 0;
        int cyc = 0;
        int drain = 0;
        int stalls = 0;
        ins_t cur;
        cmt_t e;
        logic [31:0] epc;

        for (int r = 0; r < 32; r++) arch[r] = 0;

        // Distances 1/2/3 and sequential semantics (R2, R3, R4)
        put(5, 1, 0, 0, 16'h0010, "R7");
        put(5, 2, 0, 0, 16'h0003, "R7");
        put(4, 4, 0, 0, 16'h0000, "R6");
        put(1, 3, 1, 2, 16'h0000, "R4");
        put(2, 5, 3, 1, 16'h0000, "R3");
        put(3, 6, 5, 3, 16'h0000, "R3");
        put(4, 5, 6, 6, 16'h0000, "R2");
        put(7, 5, 1, 1, 16'h0000, "R2");
        put(2, 7, 5, 2, 16'h0000, "R2");
        // Younger of two matching producers wins (R5)
        put(4, 9, 1, 0, 16'h0000, "R5");
        put(4, 9, 2, 0, 16'h0000, "R5");
        put(1, 10, 9, 9, 16'h0000, "R5");
        // Load-use on first and second source (R7)
        put(5, 11, 0, 0, 16'h0100, "R7");
        put(1, 12, 11, 1, 16'h0000, "R7");
        put(5, 26, 0, 0, 16'h0042, "R7");
        put(2, 27, 1, 26, 16'h0000, "R7");
        // Register 0 (R6)
        put(4, 0, 1, 2, 16'h0000, "R6");
        put(1, 13, 0, 1, 16'h0000, "R6");
        put(5, 0, 0, 0, 16'h0005, "R6");
        put(4, 14, 0, 2, 16'h0000, "R6");
        // Add overflow, destination also a source (R8, R9, R10)
        put(5, 15, 0, 0, 16'h7FFF, "R8");
        put(5, 16, 0, 0, 16'h7FF0, "R8");
        gap();
        put(1, 15, 16, 15, 16'h0000, "R8");
        put(4, 17, 15, 0, 16'h0000, "R10");
        put(4, 18, 16, 0, 16'h0000, "R10");
        put(1, 19, 15, 0, 16'h0000, "R9");
        put(4, 20, 17, 18, 16'h0000, "R10");
        // Subtract overflow with an empty decode slot (R8, R9, R10)
        put(5, 21, 0, 0, 16'h8000, "R8");
        gap();
        put(2, 22, 21, 15, 16'h0000, "R8");
        gap();
        put(4, 23, 1, 0, 16'h0000, "R10");
        put(4, 24, 22, 23, 16'h0000, "R9");
        put(2, 25, 21, 21, 16'h0000, "R8");
        put(4, 28, 1, 19, 16'h0000, "R11");

        rst_n = 0; in_valid = 0; in_op = 0; in_rd = 0; in_rs = 0; in_rt = 0;
        in_imm = 0; in_pc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1", "in_ready after reset", {31'd0, in_ready}, 32'd1);
        check(wb_valid == 1'b0, "R1", "wb_valid after reset", {31'd0, wb_valid}, 32'd0);
        check(exc_valid == 1'b0, "R1", "exc_valid after reset", {31'd0, exc_valid}, 32'd0);

        while (drain < 12 && cyc < 4000) begin
            if (cyc > 0) @(negedge clk);
            cyc++;
            // Observe commit port (R11 plus instruction tag)
            if (wb_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected commit rd", {27'd0, wb_rd}, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    check(wb_rd == e.rd, e.tag, "commit rd", {27'd0, wb_rd}, {27'd0, e.rd});
                    check(wb_data == e.data, e.tag, "commit data", wb_data, e.data);
                end
            end
            // Observe fault port (R8)
            if (exc_valid) begin
                if (exc_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected fault pc", exc_pc, 32'd0);
                end else begin
                    epc = exc_q.pop_front();
                    check(exc_pc == epc, "R8", "fault pc", exc_pc, epc);
                end
            end else begin
                check(exc_pc == 32'd0, "R8", "idle fault pc", exc_pc, 32'd0);
            end
            if (!in_ready) stalls++;
            // Drive the next offer and account for its acceptance
            if (idx < prog.size()) begin
                cur      = prog[idx];
                in_valid = !cur.gap;
                in_op    = cur.op;
                in_rd    = cur.rd;
                in_rs    = cur.rs;
                in_rt    = cur.rt;
                in_imm   = cur.imm;
                in_pc    = 32'h100 + 32'(idx * 4);
                if (cur.gap) begin
                    idx++;
                end else if (in_ready) begin
                    if (!(exc_valid || kill)) iss(cur, in_pc);
                    idx++;
                end
            end else begin
                in_valid = 0;
                drain++;
            end
            if (exc_valid) kill = 0;
        end

        if (cyc >= 4000) check(1'b0, "R11", "watchdog expired", cyc, 0);
        check(stalls == 2, "R7", "stall cycles", stalls, 2);
        check(exp_q.size() == 0, "R11", "commits outstanding", exp_q.size(), 0);
        check(exc_q.size() == 0, "R8", "faults outstanding", exc_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule